// File: doc/BRIEF.md
# Reset Slice Controller with Locked Access Rights

This block holds a bank of independent reset slices. Each slice drives one active-low reset output for a part of the chip. Each slice owns a 32-byte window on a plain 32-bit register bus. A slice's reset can come from three sources:

- a software pulse of fixed length;
- the power mode of an assigned CPU;
- the current setpoint number.

Only one of the two hardware sources is armed at a time.

Each slice has an authentication register. It limits which bus master may program the slice, by master ID, by privilege and by security state. Lock bits freeze its fields one group at a time, and only a block reset unlocks them. Each bus access is a single-cycle request. Reads return data in the same cycle and never change state. Writes take effect at the clock edge that samples the request. The bus has no back-pressure: every request completes in its own cycle.

Top module: `reset_slice_bank`

## Requirements
- R1: Slice i owns addresses 0x200 + 32*i upward. Within the window, authentication sits at +0x0, control at +0x4, setpoint mask at +0x8, CPU-mode mask at +0xC and status at +0x10. Other addresses read 0.
- R2: After reset, every slice output is high (released). Authentication reads 0x00060000, which is white list cores 1 and 2 with everything else clear. All other registers read 0.
- R3: In authentication, bit 0 arms the CPU-mode trigger and bit 1 arms the setpoint trigger. A write sets one and clears the other. A write with both set keeps bit 0 only, so the two never read 1 together.
- R4: Four lock bits each freeze a field until the next block reset:
  - bit 7 freezes bits 1:0;
  - bit 15 freezes the assign list in bits 11:8;
  - bit 23 freezes the white list in bits 19:16;
  - bit 31 freezes bits 25:24.
  A lock bit, once set, stays set. A write that sets a lock still updates the field it locks.
- R5: A write is dropped unless bit (16 + bus_id) of the authentication register is set. Reads return the contents whatever the master.
- R6: A write with bus_priv low is dropped unless bit 24 is set. A write with bus_secure low is dropped unless bit 25 is set.
- R7: Writing 1 to control bit 0 holds the slice output low for exactly SW_HOLD cycles, starting right after the write edge. A new start reloads the count. Control bit 0 reads 1 while the count runs.
- R8: When bit 0 is set, the output goes low one cycle after an assigned CPU enters a selected mode, and rises one cycle after it leaves. CPU0 is core 1 (assign bit 9) and CPU1 is core 2 (assign bit 10). Mode codes are run=0, wait=1, stop=2 and suspend=3. The selecting bit is 4*cpu + mode of the CPU-mode mask.
- R9: When bit 1 is set, the output is low one cycle after the setpoint input selects a set bit of the 16-bit setpoint mask.
- R10: Status bit 0 reads 1 while the slice output is low. Bit 2 latches a hardware-triggered reset and bit 3 a software start. Writing 1 to bit 2 or bit 3 clears it, and a new event in the same cycle wins.
- R11: Slices are independent: activity on one slice leaves every other slice's output and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Active-low block reset, clears all registers and locks |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_id | input | 2 | Master (core) number |
| bus_priv | input | 1 | 1 = privileged master |
| bus_secure | input | 1 | 1 = secure master |
| bus_rdata | output | 32 | Read data, same cycle as the request |
| cpu0_mode | input | 2 | Power mode of CPU0 (core 1) |
| cpu1_mode | input | 2 | Power mode of CPU1 (core 2) |
| setpoint | input | 4 | Current setpoint number |
| slice_rst_n | output | N_SLICES | Active-low reset per slice |

## Verification
The hardest state to reach is a slice whose fields are locked while access is also narrowed. Only a master that still passes the white list, privilege and security checks can attempt the writes that the locks must reject. Once access is lost, no further writes to that slice can happen. The stimulus therefore runs in a fixed order. First an authorised master sets each field together with its lock in the same write. Then it tries to overwrite every frozen field. Last, a block reset shows the locks releasing. The CPU-mode checks pick a mode whose mask bit is set but whose CPU is not assigned, to show that the assign list gates the trigger.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // window layout
  localparam int unsigned WIN_SHIFT = 5;
  localparam logic [4:0] OFF_AUTH  = 5'h00;
  localparam logic [4:0] OFF_CTRL  = 5'h04;
  localparam logic [4:0] OFF_SPMSK = 5'h08;
  localparam logic [4:0] OFF_PMMSK = 5'h0C;
  localparam logic [4:0] OFF_STAT  = 5'h10;

  // authentication bit positions
  localparam int unsigned B_PMODE  = 0;
  localparam int unsigned B_SPMODE = 1;
  localparam int unsigned B_LK_MOD = 7;
  localparam int unsigned B_ASG    = 8;
  localparam int unsigned B_LK_ASG = 15;
  localparam int unsigned B_WL     = 16;
  localparam int unsigned B_LK_WL  = 23;
  localparam int unsigned B_USER   = 24;
  localparam int unsigned B_NSEC   = 25;
  localparam int unsigned B_LK_ACC = 31;

  localparam int unsigned CORE_ID_W  = 2;
  localparam int unsigned CORE_SLOTS = 1 << CORE_ID_W;
  localparam int unsigned NCPU       = 2;
  localparam int unsigned CPU0_CORE  = 1;
  localparam int unsigned MODES      = 4;
  localparam int unsigned SP_IDX_W   = 4;
  localparam int unsigned SP_W       = 1 << SP_IDX_W;
  localparam logic [CORE_SLOTS-1:0] WL_RESET = 4'b0110;

  typedef enum logic [1:0] {PM_RUN, PM_WAIT, PM_STOP, PM_SUSP} pmode_e;
endpackage

// File: rtl/rsc_auth.sv
module rsc_auth
  import rsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  wr,
  input  logic [31:0]           wdata,
  output logic [31:0]           auth_q,
  output logic                  pm_en,
  output logic                  sp_en,
  output logic [CORE_SLOTS-1:0] asg_list,
  output logic [CORE_SLOTS-1:0] white_list,
  output logic                  user_ok,
  output logic                  nsec_ok
);
  logic [1:0]            mode_q;
  logic [1:0]            acc_q;
  logic [CORE_SLOTS-1:0] asg_q, wl_q;
  logic                  lk_mod, lk_asg, lk_wl, lk_acc;

  // field updates use the lock state before this write
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      acc_q  <= '0;
      asg_q  <= '0;
      wl_q   <= WL_RESET;
      lk_mod <= 1'b0;
      lk_asg <= 1'b0;
      lk_wl  <= 1'b0;
      lk_acc <= 1'b0;
    end else if (wr) begin
      if (!lk_mod) begin
        mode_q[0] <= wdata[B_PMODE];
        mode_q[1] <= wdata[B_SPMODE] & ~wdata[B_PMODE];
      end
      if (!lk_asg) asg_q <= wdata[B_ASG +: CORE_SLOTS];
      if (!lk_wl)  wl_q  <= wdata[B_WL +: CORE_SLOTS];
      if (!lk_acc) acc_q <= wdata[B_NSEC:B_USER];
      lk_mod <= lk_mod | wdata[B_LK_MOD];
      lk_asg <= lk_asg | wdata[B_LK_ASG];
      lk_wl  <= lk_wl  | wdata[B_LK_WL];
      lk_acc <= lk_acc | wdata[B_LK_ACC];
    end
  end

  assign auth_q = {lk_acc, 5'b0, acc_q, lk_wl, 3'b0, wl_q,
                   lk_asg, 3'b0, asg_q, lk_mod, 5'b0, mode_q};
  assign pm_en      = mode_q[0];
  assign sp_en      = mode_q[1];
  assign asg_list   = asg_q;
  assign white_list = wl_q;
  assign user_ok    = acc_q[0];
  assign nsec_ok    = acc_q[1];
endmodule

// File: rtl/rsc_trig.sv
module rsc_trig
  import rsc_pkg::*;
(
  input  logic                       pm_en,
  input  logic                       sp_en,
  input  logic [CORE_SLOTS-1:0]      asg_list,
  input  logic [NCPU*MODES-1:0]      pm_mask,
  input  logic [SP_W-1:0]            sp_mask,
  input  logic [NCPU-1:0][1:0]       cpu_mode,
  input  logic [SP_IDX_W-1:0]        setpoint,
  output logic                       trig
);
  logic [NCPU-1:0] cpu_hit;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_hit[c] = asg_list[CPU0_CORE + c] && pm_mask[MODES*c + int'(cpu_mode[c])];
  end

  assign trig = (pm_en && |cpu_hit) || (sp_en && sp_mask[setpoint]);
endmodule

// File: rtl/rsc_slice.sv
module rsc_slice
  import rsc_pkg::*;
#(
  parameter int unsigned SW_HOLD = 6
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  sel,
  input  logic                  we,
  input  logic [4:0]            off,
  input  logic [31:0]           wdata,
  input  logic [CORE_ID_W-1:0]  id,
  input  logic                  priv,
  input  logic                  secure,
  input  logic [NCPU-1:0][1:0]  cpu_mode,
  input  logic [SP_IDX_W-1:0]   setpoint,
  output logic [31:0]           rdata,
  output logic                  rst_out_n,
  output logic                  sw_go,
  output logic                  hw_trig
);
  localparam int unsigned CNT_W = $clog2(SW_HOLD + 1);

  logic [31:0]           auth_q;
  logic                  pm_en, sp_en, user_ok, nsec_ok;
  logic [CORE_SLOTS-1:0] asg_list, white_list;
  logic [SP_W-1:0]       sp_mask;
  logic [NCPU*MODES-1:0] pm_mask;
  logic [CNT_W-1:0]      hold_cnt;
  logic                  hw_q, hw_flag, sw_flag, busy, wr_ok;

  assign wr_ok = sel && we && white_list[id] && (priv || user_ok) && (secure || nsec_ok);
  assign sw_go = wr_ok && (off == OFF_CTRL) && wdata[0];

  rsc_auth u_auth (
    .clk(clk), .rst_ni(rst_ni), .wr(wr_ok && (off == OFF_AUTH)), .wdata(wdata),
    .auth_q(auth_q), .pm_en(pm_en), .sp_en(sp_en), .asg_list(asg_list),
    .white_list(white_list), .user_ok(user_ok), .nsec_ok(nsec_ok)
  );

  rsc_trig u_trig (
    .pm_en(pm_en), .sp_en(sp_en), .asg_list(asg_list), .pm_mask(pm_mask),
    .sp_mask(sp_mask), .cpu_mode(cpu_mode), .setpoint(setpoint), .trig(hw_trig)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_mask  <= '0;
      pm_mask  <= '0;
      hold_cnt <= '0;
      hw_q     <= 1'b0;
      hw_flag  <= 1'b0;
      sw_flag  <= 1'b0;
    end else begin
      hw_q <= hw_trig;
      if (wr_ok && off == OFF_SPMSK) sp_mask <= wdata[SP_W-1:0];
      if (wr_ok && off == OFF_PMMSK) pm_mask <= wdata[NCPU*MODES-1:0];
      if (sw_go)              hold_cnt <= CNT_W'(SW_HOLD);
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
      if (hw_trig)                               hw_flag <= 1'b1;
      else if (wr_ok && off == OFF_STAT && wdata[2]) hw_flag <= 1'b0;
      if (sw_go)                                 sw_flag <= 1'b1;
      else if (wr_ok && off == OFF_STAT && wdata[3]) sw_flag <= 1'b0;
    end
  end

  assign busy      = (hold_cnt != 0);
  assign rst_out_n = ~(busy | hw_q);

  always_comb begin
    case (off)
      OFF_AUTH:  rdata = auth_q;
      OFF_CTRL:  rdata = {31'b0, busy};
      OFF_SPMSK: rdata = {{(32-SP_W){1'b0}}, sp_mask};
      OFF_PMMSK: rdata = {{(32-NCPU*MODES){1'b0}}, pm_mask};
      OFF_STAT:  rdata = {28'b0, sw_flag, hw_flag, 1'b0, ~rst_out_n};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/reset_slice_bank.sv
module reset_slice_bank
  import rsc_pkg::*;
#(
  parameter int unsigned N_SLICES = 4,
  parameter int unsigned SW_HOLD  = 6,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [1:0]           bus_id,
  input  logic                 bus_priv,
  input  logic                 bus_secure,
  output logic [31:0]          bus_rdata,
  input  logic [1:0]           cpu0_mode,
  input  logic [1:0]           cpu1_mode,
  input  logic [3:0]           setpoint,
  output logic [N_SLICES-1:0]  slice_rst_n
);
  localparam int unsigned IDX_W = 4;
  localparam int unsigned HI_W  = ADDR_W - WIN_SHIFT - IDX_W;

  logic [IDX_W-1:0]           win_idx;
  logic                       in_bank;
  logic [NCPU-1:0][1:0]       modes;
  logic [N_SLICES-1:0][31:0]  slice_rd;
  logic [N_SLICES-1:0]        sw_go, hw_trig;

  assign win_idx = bus_addr[WIN_SHIFT +: IDX_W];
  assign in_bank = bus_req && (bus_addr[ADDR_W-1 -: HI_W] == HI_W'(1))
                   && (32'(win_idx) < N_SLICES);
  assign modes   = {cpu1_mode, cpu0_mode};

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    rsc_slice #(.SW_HOLD(SW_HOLD)) u_slice (
      .clk(clk), .rst_ni(rst_ni),
      .sel(in_bank && win_idx == IDX_W'(i)), .we(bus_we),
      .off(bus_addr[WIN_SHIFT-1:0]), .wdata(bus_wdata),
      .id(bus_id), .priv(bus_priv), .secure(bus_secure),
      .cpu_mode(modes), .setpoint(setpoint),
      .rdata(slice_rd[i]), .rst_out_n(slice_rst_n[i]),
      .sw_go(sw_go[i]), .hw_trig(hw_trig[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_SLICES; i++)
      if (in_bank && win_idx == IDX_W'(i)) bus_rdata = slice_rd[i];
  end
endmodule

// File: rtl/reset_slice_bank_chk.sv
module reset_slice_bank_chk #(
  parameter int unsigned N_SLICES = 4,
  parameter int unsigned SW_HOLD  = 6,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                bus_req,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [N_SLICES-1:0] slice_rst_n,
  input logic [N_SLICES-1:0] sw_go,
  input logic [N_SLICES-1:0] hw_trig
);
  localparam int unsigned CNT_W   = $clog2(SW_HOLD + 1);
  localparam logic [31:0] LK_MASK = 32'h8080_8080;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_AUTH = ADDR_W'(32'h200 + 32 * i);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(32'h210 + 32 * i);
    logic rd_auth, rd_stat;
    logic [CNT_W-1:0] win_cnt;

    assign rd_auth = bus_req && !bus_we && bus_addr == A_AUTH;
    assign rd_stat = bus_req && !bus_we && bus_addr == A_STAT;

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)           win_cnt <= '0;
      else if (sw_go[i])     win_cnt <= CNT_W'(SW_HOLD);
      else if (win_cnt != 0) win_cnt <= win_cnt - 1'b1;
    end

    assert_mode_excl_R3: assert property (@(posedge clk) disable iff (!rst_ni)
      rd_auth |-> (bus_rdata & 32'h3) != 32'h3);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      (rd_auth && $past(rd_auth)) |-> (($past(bus_rdata) & LK_MASK & ~bus_rdata) == 32'h0));

    assert_sw_start_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      sw_go[i] |=> !slice_rst_n[i]);

    assert_sw_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      (win_cnt != 0) |-> !slice_rst_n[i]);

    // covers R8 and R9: any armed hardware source
    assert_hw_low_R8: assert property (@(posedge clk) disable iff (!rst_ni)
      hw_trig[i] |=> !slice_rst_n[i]);

    assert_stat_busy_R10: assert property (@(posedge clk) disable iff (!rst_ni)
      rd_stat |-> ((bus_rdata & 32'h1) != 0) == !slice_rst_n[i]);
  end
endmodule

bind reset_slice_bank reset_slice_bank_chk #(
  .N_SLICES(N_SLICES), .SW_HOLD(SW_HOLD), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .slice_rst_n(slice_rst_n),
  .sw_go(sw_go), .hw_trig(hw_trig)
);

// File: tb/tb_reset_slice_bank.sv
module tb_reset_slice_bank;
  localparam int N = 4;
  localparam int HOLD = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_id = 2'd1;
  logic        bus_priv = 1'b1, bus_secure = 1'b1;
  logic [31:0] bus_rdata;
  logic [1:0]  cpu0_mode = 2'd0, cpu1_mode = 2'd0;
  logic [3:0]  setpoint = '0;
  logic [N-1:0] slice_rst_n;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  reset_slice_bank #(.N_SLICES(N), .SW_HOLD(HOLD), .ADDR_W(12)) dut (
    .clk(clk), .rst_ni(rst_ni), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_id(bus_id),
    .bus_priv(bus_priv), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
    .cpu0_mode(cpu0_mode), .cpu1_mode(cpu1_mode), .setpoint(setpoint),
    .slice_rst_n(slice_rst_n)
  );

  function automatic logic [11:0] adr(int s, int off);
    return 12'(32'h200 + 32 * s + off);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int s, int off, logic [31:0] d,
                    logic [1:0] id = 2'd1, logic pr = 1'b1, logic se = 1'b1);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = adr(s, off); bus_wdata = d;
    bus_id = id; bus_priv = pr; bus_secure = se;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_id = 2'd1; bus_priv = 1'b1; bus_secure = 1'b1;
  endtask

  task automatic chk_rd(string tag, int s, int off, logic [31:0] exp, logic [1:0] id = 2'd3);
    logic [31:0] d;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = adr(s, off);
    bus_id = id; bus_priv = 1'b0; bus_secure = 1'b0;
    #1 d = bus_rdata;
    bus_req = 1'b0; bus_id = 2'd1; bus_priv = 1'b1; bus_secure = 1'b1;
    chk(tag, d, exp);
  endtask

  task automatic t_reset_state();
    chk("R2 outputs released", 32'(slice_rst_n), 32'hF);
    chk_rd("R2 auth reset", 0, 'h0, 32'h0006_0000);
    chk_rd("R2 ctrl reset", 2, 'h4, 32'h0);
    chk_rd("R2 status reset", 3, 'h10, 32'h0);
    chk_rd("R1 hole in window", 0, 'h14, 32'h0);
  endtask

  task automatic t_sw_reset();
    wr(1, 'h4, 32'h1);
    chk("R7 low after start", 32'(slice_rst_n), 32'hD);   // R11 others stay high
    chk_rd("R7 ctrl busy", 1, 'h4, 32'h1);
    chk_rd("R10 status under sw reset", 1, 'h10, 32'h9);
    repeat (3) @(negedge clk);
    chk("R7 still low at last cycle", 32'(slice_rst_n[1]), 32'h0);
    @(negedge clk);
    chk("R7 released after hold", 32'(slice_rst_n[1]), 32'h1);
    chk_rd("R10 sw flag kept", 1, 'h10, 32'h8);
    wr(1, 'h10, 32'h8);
    chk_rd("R10 sw flag w1c", 1, 'h10, 32'h0);
    chk_rd("R11 neighbour status clean", 0, 'h10, 32'h0);
  endtask

  task automatic t_cpu_mode();
    wr(2, 'h0, 32'h0006_0201);          // R8 arm CPU-mode trigger, assign core 1
    wr(2, 'hC, 32'h0000_0004);          // CPU0 stop
    cpu0_mode = 2'd2;
    @(negedge clk);
    chk("R8 low in selected mode", 32'(slice_rst_n[2]), 32'h0);
    cpu0_mode = 2'd0;
    @(negedge clk);
    chk("R8 released on leaving mode", 32'(slice_rst_n[2]), 32'h1);
    wr(2, 'hC, 32'h0000_0044);
    cpu1_mode = 2'd2;
    @(negedge clk);
    @(negedge clk);
    chk("R8 unassigned cpu ignored", 32'(slice_rst_n[2]), 32'h1);
    cpu1_mode = 2'd0;
    chk_rd("R10 hw flag", 2, 'h10, 32'h4);
    wr(2, 'h10, 32'h4);
    chk_rd("R10 hw flag w1c", 2, 'h10, 32'h0);
  endtask

  task automatic t_mode_excl();
    wr(2, 'h0, 32'h0006_0202);
    chk_rd("R3 setpoint clears cpu-mode", 2, 'h0, 32'h0006_0202);
    wr(2, 'h0, 32'h0006_0203);
    chk_rd("R3 both written keeps bit0", 2, 'h0, 32'h0006_0201);
  endtask

  task automatic t_setpoint();
    wr(3, 'h0, 32'h0006_0002);
    wr(3, 'h8, 32'h0000_0020);
    setpoint = 4'd5;
    @(negedge clk);
    chk("R9 low at selected setpoint", 32'(slice_rst_n[3]), 32'h0);
    setpoint = 4'd6;
    @(negedge clk);
    chk("R9 released at other setpoint", 32'(slice_rst_n[3]), 32'h1);
    setpoint = 4'd0;
    chk_rd("R10 hw flag from setpoint", 3, 'h10, 32'h4);
  endtask

  task automatic t_white_list();
    wr(0, 'h8, 32'h0000_1111, 2'd3);
    chk_rd("R5 unlisted id dropped", 0, 'h8, 32'h0);
    wr(0, 'h8, 32'h0000_00AA, 2'd2);
    chk_rd("R5 listed id accepted", 0, 'h8, 32'h0000_00AA);
    wr(0, 'h0, 32'h0002_0000, 2'd2);
    wr(0, 'h8, 32'h0000_0077, 2'd2);
    chk_rd("R5 removed id dropped", 0, 'h8, 32'h0000_00AA, 2'd2);
  endtask

  task automatic t_priv_sec();
    wr(0, 'h8, 32'h0000_0055, 2'd1, 1'b0, 1'b1);
    chk_rd("R6 user write dropped", 0, 'h8, 32'h0000_00AA);
    wr(0, 'h0, 32'h0102_0000);
    wr(0, 'h8, 32'h0000_0055, 2'd1, 1'b0, 1'b1);
    chk_rd("R6 user write allowed", 0, 'h8, 32'h0000_0055);
    wr(0, 'h8, 32'h0000_0011, 2'd1, 1'b1, 1'b0);
    chk_rd("R6 nonsecure write dropped", 0, 'h8, 32'h0000_0055);
    wr(0, 'h0, 32'h0302_0000);
    wr(0, 'h8, 32'h0000_0011, 2'd1, 1'b1, 1'b0);
    chk_rd("R6 nonsecure write allowed", 0, 'h8, 32'h0000_0011);
  endtask

  task automatic t_locks();
    wr(1, 'h0, 32'h0006_8200);
    wr(1, 'h0, 32'h0006_0400);
    chk_rd("R4 assign list frozen", 1, 'h0, 32'h0006_8200);
    wr(1, 'h0, 32'h8006_0081);
    chk_rd("R4 mode and access lock set", 1, 'h0, 32'h8006_8281);
    wr(1, 'h0, 32'h0306_0002);
    chk_rd("R4 mode and access frozen", 1, 'h0, 32'h8006_8281);
    wr(1, 'h0, 32'h0082_0000);
    chk_rd("R4 white list lock same write", 1, 'h0, 32'h8082_8281);
    wr(1, 'h0, 32'h0006_0000);
    chk_rd("R4 white list frozen", 1, 'h0, 32'h8082_8281);
    @(negedge clk) rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    chk_rd("R4 reset clears locks", 1, 'h0, 32'h0006_0000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_sw_reset();
    t_cpu_mode();
    t_mode_excl();
    t_setpoint();
    t_white_list();
    t_priv_sec();
    t_locks();
    finish_run();
  end

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule